// File: doc/BRIEF.md
# Physical Memory Protection Range and Permission Checker

This combinational block decides whether a memory access may proceed under a set of protection rules. It receives every rule's configuration byte and address register, two security policy bits, and a description of one access: its byte address, its size, the read/write/execute operations it asks for and the privilege mode it runs in. It returns the set of operations the access is allowed and a single pass flag.

Each rule turns its address register into an inclusive byte range. The range is either a naturally aligned power-of-two block, a top-of-range span that starts at the previous rule's address, or a four-byte word. Rules are searched from index 0 upward. The first rule that contains both the first and the last byte of the access decides the outcome. A rule that contains only one of those two bytes fails the access. When no rule matches, a default policy set by the two security bits applies. A strict machine-lockdown bit switches rule permissions to a sixteen-entry table. That table is indexed by the lock and permission bits and has one column for machine mode and one for the other modes.

The block is placed between the address path of a core and its memory interface. Rule registers are held elsewhere and are presented here as flat vectors.

Top module: `pmp_check`

## Requirements
- R1: A rule whose mode field (config bits 4:3) is 3 covers an aligned block of 2^(k+3) bytes, where k is the number of trailing one bits in its address register. The block contains byte address (register << 2). An all-ones register covers the whole address space, including bytes past the top.
- R2: A rule with mode field 1 covers the bytes from (previous register << 2) up to (own register << 2) - 1. Rule 0 uses 0 as its previous register. If the previous value is not below its own, the rule matches nothing.
- R3: A rule with mode field 2 covers exactly the four bytes starting at (register << 2). A rule with mode field 0 never matches and never causes a partial failure.
- R4: When several rules contain the whole access, the lowest-indexed one decides the result. A rule with a higher index is consulted only when every rule below it misses both bytes.
- R5: If the first rule that touches the access contains exactly one of its first and last bytes, the allowed mask is 0 and pass is 0, whatever any later rule holds.
- R6: With the lockdown bit clear, a matched rule grants its config bits 2:0 (bit 0 read, bit 1 write, bit 2 execute). An exception applies in machine mode (mode 3) when lock bit 7 is clear: the access then gets all three.
- R7: With the lockdown bit set and mode 3, the index {lock, read, write, execute} gives this mask: none for 0, 1 and 4 to 8; read-write for 2, 3 and 14; execute for 9 and 10; read-execute for 11 and 13; read for 12 and 15.
- R8: With the lockdown bit set and a mode other than 3, the same index gives this mask: none for 0, 8, 9, 12, 13 and 14; execute for 1, 10 and 11; read for 2, 4 and 15; read-write for 3 and 6; read-execute for 5; all three for 7.
- R9: With no matching rule, the whitelist bit denies everything. Otherwise, with the lockdown bit set, mode 3 gets read-write if execute is not requested and nothing if it is. With neither bit set, mode 3 gets all three and every other mode gets nothing.
- R10: Pass is 1 exactly when the access is not partially matched and every requested operation bit is present in the allowed mask. The request uses the same bit order as R6.
- R11: The size input encodes 1, 2, 4 or 8 bytes as 0 to 3. The last byte is address + size - 1, computed one bit wider than the address, so an access may run past the top of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_flat | input | NUM_ENTRIES*8 | Config byte of rule i at bits [8i+7:8i] |
| addr_flat | input | NUM_ENTRIES*ADDR_REG_W | Address register of rule i at [ADDR_REG_W*i +: ADDR_REG_W] |
| sec_lockdown | input | 1 | Strict machine-lockdown policy bit |
| sec_whitelist | input | 1 | Deny-by-default policy bit |
| acc_addr | input | ADDR_REG_W+2 | Byte address of the access |
| acc_size_log2 | input | 2 | Log2 of the access size in bytes |
| acc_req | input | 3 | Requested operations: read, write, execute |
| acc_mode | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| allow_o | output | 3 | Allowed operations |
| pass_o | output | 1 | Access permitted |

## Verification
The block holds no state, so a wrong decode shows on the outputs as soon as the inputs settle. A bad bound moves the point where the allowed mask changes by a byte or a block. An error in the priority chain makes an overlapped address show a later rule's permissions. A lost partial flag turns a straddling access that should fail into one that passes. The sweeps put every byte address of a small space, at every size, against overlapping, empty, locked and whole-space rules, so each such error reaches the ports on the exact address where it first applies.

// File: rtl/pmp_check_pkg.sv
package pmp_check_pkg;

   typedef enum logic [1:0] {
      AM_OFF   = 2'd0,
      AM_TOR   = 2'd1,
      AM_NA4   = 2'd2,
      AM_NAPOT = 2'd3
   } amatch_e;

   typedef logic [2:0] perm_t;

   localparam perm_t PERM_NONE = 3'b000;
   localparam perm_t PERM_R    = 3'b001;
   localparam perm_t PERM_RW   = 3'b011;
   localparam perm_t PERM_X    = 3'b100;
   localparam perm_t PERM_RX   = 3'b101;
   localparam perm_t PERM_RWX  = 3'b111;

   localparam int    CFG_W      = 8;
   localparam int    CFG_LOCK   = 7;
   localparam int    CFG_AM_LO  = 3;
   localparam logic [1:0] MODE_MACHINE = 2'd3;

   typedef struct packed {
      logic lock;
      logic x;
      logic w;
      logic r;
   } rule_bits_t;

   function automatic logic [3:0] lrwx_index(input rule_bits_t rb);
      return {rb.lock, rb.r, rb.w, rb.x};
   endfunction

   function automatic perm_t lockdown_machine(input logic [3:0] idx);
      perm_t p;
      unique case (idx)
         4'd2, 4'd3, 4'd14:  p = PERM_RW;
         4'd9, 4'd10:        p = PERM_X;
         4'd11, 4'd13:       p = PERM_RX;
         4'd12, 4'd15:       p = PERM_R;
         default:            p = PERM_NONE;
      endcase
      return p;
   endfunction

   function automatic perm_t lockdown_other(input logic [3:0] idx);
      perm_t p;
      unique case (idx)
         4'd1, 4'd10, 4'd11: p = PERM_X;
         4'd2, 4'd4, 4'd15:  p = PERM_R;
         4'd3, 4'd6:         p = PERM_RW;
         4'd5:               p = PERM_RX;
         4'd7:               p = PERM_RWX;
         default:            p = PERM_NONE;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/pmp_region_decode.sv
module pmp_region_decode
   import pmp_check_pkg::*;
#(
   parameter int ADDR_REG_W = 30,
   localparam int EXT_W = ADDR_REG_W + 3
) (
   input  amatch_e                 amode,
   input  logic [ADDR_REG_W-1:0]   addr_prev,
   input  logic [ADDR_REG_W-1:0]   addr_this,
   output logic                    active,
   output logic [EXT_W-1:0]        lo,
   output logic [EXT_W-1:0]        hi
);

   logic [EXT_W-1:0] this_b;
   logic [EXT_W-1:0] prev_b;
   logic [EXT_W-1:0] napot_a;
   logic [EXT_W-1:0] napot_a1;

   assign this_b   = {1'b0, addr_this, 2'b00};
   assign prev_b   = {1'b0, addr_prev, 2'b00};
   assign napot_a  = {1'b0, addr_this, 2'b11};
   assign napot_a1 = napot_a + EXT_W'(1);

   always_comb begin
      active = 1'b0;
      lo     = '0;
      hi     = '0;
      unique case (amode)
         AM_TOR: begin
            active = (prev_b < this_b);
            lo     = prev_b;
            hi     = this_b - EXT_W'(1);
         end
         AM_NA4: begin
            active = 1'b1;
            lo     = this_b;
            hi     = this_b + EXT_W'(3);
         end
         AM_NAPOT: begin
            active = 1'b1;
            lo     = napot_a & napot_a1;
            hi     = napot_a | napot_a1;
         end
         default: begin
            active = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match #(
   parameter int EXT_W = 33
) (
   input  logic             active,
   input  logic [EXT_W-1:0] lo,
   input  logic [EXT_W-1:0] hi,
   input  logic [EXT_W-1:0] first_b,
   input  logic [EXT_W-1:0] last_b,
   output logic             full,
   output logic             part
);

   logic first_in;
   logic last_in;

   assign first_in = active && (first_b >= lo) && (first_b <= hi);
   assign last_in  = active && (last_b  >= lo) && (last_b  <= hi);
   assign full     = first_in & last_in;
   assign part     = first_in ^ last_in;

endmodule

// File: rtl/pmp_prio_select.sv
module pmp_prio_select
   import pmp_check_pkg::*;
#(
   parameter int NUM_ENTRIES = 16
) (
   input  logic [NUM_ENTRIES-1:0]   full,
   input  logic [NUM_ENTRIES-1:0]   part,
   input  logic [NUM_ENTRIES*4-1:0] rule_flat,
   output logic [NUM_ENTRIES-1:0]   grant,
   output logic                     sel_valid,
   output logic                     sel_partial,
   output rule_bits_t               sel_rule
);

   logic [NUM_ENTRIES:0] seen;

   assign seen[0] = 1'b0;

   for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_chain
      logic touch;
      assign touch        = full[gi] | part[gi];
      assign grant[gi]    = touch & ~seen[gi];
      assign seen[gi + 1] = seen[gi] | touch;
   end

   assign sel_valid   = seen[NUM_ENTRIES];
   assign sel_partial = |(grant & part);

   always_comb begin
      sel_rule = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (grant[i]) begin
            sel_rule = sel_rule | rule_bits_t'(rule_flat[i*4 +: 4]);
         end
      end
   end

endmodule

// File: rtl/pmp_perm_resolve.sv
module pmp_perm_resolve
   import pmp_check_pkg::*;
#(
   parameter bit ENHANCED = 1'b1
) (
   input  logic       sel_valid,
   input  logic       sel_partial,
   input  rule_bits_t sel_rule,
   input  logic       sec_lockdown,
   input  logic       sec_whitelist,
   input  logic [1:0] acc_mode,
   input  perm_t      acc_req,
   output perm_t      allow_o,
   output logic       pass_o
);

   logic  is_machine;
   perm_t legacy_hit;
   perm_t allow_c;

   assign is_machine = (acc_mode == MODE_MACHINE);
   assign legacy_hit = (is_machine && !sel_rule.lock) ? PERM_RWX
                                                      : {sel_rule.x, sel_rule.w, sel_rule.r};

   if (ENHANCED) begin : g_enh
      always_comb begin
         if (sel_partial) begin
            allow_c = PERM_NONE;
         end else if (sel_valid) begin
            if (!sec_lockdown)    allow_c = legacy_hit;
            else if (is_machine)  allow_c = lockdown_machine(lrwx_index(sel_rule));
            else                  allow_c = lockdown_other(lrwx_index(sel_rule));
         end else if (sec_whitelist) begin
            allow_c = PERM_NONE;
         end else if (sec_lockdown) begin
            allow_c = (is_machine && !acc_req[2]) ? PERM_RW : PERM_NONE;
         end else begin
            allow_c = is_machine ? PERM_RWX : PERM_NONE;
         end
      end
   end else begin : g_base
      logic unused_sec;
      assign unused_sec = sec_lockdown ^ sec_whitelist;
      always_comb begin
         if (sel_partial)     allow_c = PERM_NONE;
         else if (sel_valid)  allow_c = legacy_hit;
         else                 allow_c = is_machine ? PERM_RWX : PERM_NONE;
      end
   end

   assign allow_o = allow_c;
   assign pass_o  = !sel_partial && ((acc_req & ~allow_c) == PERM_NONE);

endmodule

// File: rtl/pmp_check.sv
module pmp_check
   import pmp_check_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int ADDR_REG_W  = 30,
   parameter bit ENHANCED    = 1'b1
) (
   input  logic [NUM_ENTRIES*8-1:0]          cfg_flat,
   input  logic [NUM_ENTRIES*ADDR_REG_W-1:0] addr_flat,
   input  logic                              sec_lockdown,
   input  logic                              sec_whitelist,
   input  logic [ADDR_REG_W+1:0]             acc_addr,
   input  logic [1:0]                        acc_size_log2,
   input  logic [2:0]                        acc_req,
   input  logic [1:0]                        acc_mode,
   output logic [2:0]                        allow_o,
   output logic                              pass_o
);

   localparam int PA_W  = ADDR_REG_W + 2;
   localparam int EXT_W = PA_W + 1;

   if (NUM_ENTRIES < 1) begin : g_bad_entries
      $error("pmp_check: NUM_ENTRIES must be at least 1");
   end
   if (ADDR_REG_W < 3) begin : g_bad_width
      $error("pmp_check: ADDR_REG_W must be at least 3");
   end

   logic [EXT_W-1:0]         first_b;
   logic [EXT_W-1:0]         last_b;
   logic [EXT_W-1:0]         size_b;
   logic [NUM_ENTRIES-1:0]   full;
   logic [NUM_ENTRIES-1:0]   part;
   logic [NUM_ENTRIES*4-1:0] rule_flat;
   logic [NUM_ENTRIES*2-1:0] unused_cfg_bits;
   logic [NUM_ENTRIES-1:0]   grant;
   logic                     sel_valid;
   logic                     sel_partial;
   rule_bits_t               sel_rule;

   assign size_b  = EXT_W'(1) << acc_size_log2;
   assign first_b = {1'b0, acc_addr};
   assign last_b  = first_b + size_b - EXT_W'(1);

   for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_entry
      logic [CFG_W-1:0]      cfg_b;
      logic [ADDR_REG_W-1:0] prev_a;
      logic                  active;
      logic [EXT_W-1:0]      lo;
      logic [EXT_W-1:0]      hi;

      assign cfg_b = cfg_flat[gi*CFG_W +: CFG_W];

      if (gi == 0) begin : g_first
         assign prev_a = '0;
      end else begin : g_rest
         assign prev_a = addr_flat[(gi-1)*ADDR_REG_W +: ADDR_REG_W];
      end

      assign rule_flat[gi*4 +: 4]       = {cfg_b[CFG_LOCK], cfg_b[2:0]};
      assign unused_cfg_bits[gi*2 +: 2] = cfg_b[6:5];

      pmp_region_decode #(
         .ADDR_REG_W (ADDR_REG_W)
      ) u_decode (
         .amode     (amatch_e'(cfg_b[CFG_AM_LO +: 2])),
         .addr_prev (prev_a),
         .addr_this (addr_flat[gi*ADDR_REG_W +: ADDR_REG_W]),
         .active    (active),
         .lo        (lo),
         .hi        (hi)
      );

      pmp_entry_match #(
         .EXT_W (EXT_W)
      ) u_match (
         .active  (active),
         .lo      (lo),
         .hi      (hi),
         .first_b (first_b),
         .last_b  (last_b),
         .full    (full[gi]),
         .part    (part[gi])
      );
   end

   pmp_prio_select #(
      .NUM_ENTRIES (NUM_ENTRIES)
   ) u_select (
      .full        (full),
      .part        (part),
      .rule_flat   (rule_flat),
      .grant       (grant),
      .sel_valid   (sel_valid),
      .sel_partial (sel_partial),
      .sel_rule    (sel_rule)
   );

   pmp_perm_resolve #(
      .ENHANCED (ENHANCED)
   ) u_resolve (
      .sel_valid     (sel_valid),
      .sel_partial   (sel_partial),
      .sel_rule      (sel_rule),
      .sec_lockdown  (sec_lockdown),
      .sec_whitelist (sec_whitelist),
      .acc_mode      (acc_mode),
      .acc_req       (acc_req),
      .allow_o       (allow_o),
      .pass_o        (pass_o)
   );

endmodule

// File: rtl/pmp_check_sva.sv
module pmp_check_sva #(
   parameter int NUM_ENTRIES = 16,
   parameter bit ENHANCED    = 1'b1
) (
   input logic                   sec_lockdown,
   input logic                   sec_whitelist,
   input logic [2:0]             acc_req,
   input logic [1:0]             acc_mode,
   input logic [2:0]             allow_o,
   input logic                   pass_o,
   input logic [NUM_ENTRIES-1:0] grant,
   input logic                   sel_valid,
   input logic                   sel_partial
);

   always_comb begin
      assert_grant_onehot_R4: assert ($onehot0(grant))
         else $error("more than one rule selected");

      if (sel_partial) begin
         assert_partial_denied_R5: assert (!pass_o && allow_o == 3'b000)
            else $error("partial match not denied");
      end

      if (pass_o) begin
         assert_pass_covers_req_R10: assert ((acc_req & ~allow_o) == 3'b000)
            else $error("pass with missing permission");
      end

      if (ENHANCED && !sel_valid && sec_whitelist) begin
         assert_whitelist_deny_R9: assert (allow_o == 3'b000)
            else $error("whitelist default not denied");
      end

      if (!sel_valid && !sec_whitelist && !sec_lockdown) begin
         assert_nomatch_default_R9: assert (allow_o == ((acc_mode == 2'd3) ? 3'b111 : 3'b000))
            else $error("plain default mask wrong");
      end

      if (ENHANCED && sec_lockdown && sel_valid && !sel_partial && acc_mode == 2'd3) begin
         assert_lockdown_machine_no_rwx_R7: assert (allow_o != 3'b111)
            else $error("machine granted all under lockdown");
      end
   end

endmodule

bind pmp_check pmp_check_sva #(
   .NUM_ENTRIES (NUM_ENTRIES),
   .ENHANCED    (ENHANCED)
) u_sva (
   .sec_lockdown  (sec_lockdown),
   .sec_whitelist (sec_whitelist),
   .acc_req       (acc_req),
   .acc_mode      (acc_mode),
   .allow_o       (allow_o),
   .pass_o        (pass_o),
   .grant         (grant),
   .sel_valid     (sel_valid),
   .sel_partial   (sel_partial)
);

// File: tb/pmp_check_bench.sv
module pmp_check_bench;

   localparam int BN  = 4;
   localparam int BAW = 6;
   localparam int BPA = BAW + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [BN*8-1:0]   cfg_flat;
   logic [BN*BAW-1:0] addr_flat;
   logic              sec_lockdown;
   logic              sec_whitelist;
   logic [BPA-1:0]    acc_addr;
   logic [1:0]        acc_size_log2;
   logic [2:0]        acc_req;
   logic [1:0]        acc_mode;
   logic [2:0]        allow_o;
   logic              pass_o;

   logic [7:0] cfg_m  [BN];
   int         areg_m [BN];
   int         n_vec = 0;
   int         n_bad = 0;
   bit         done  = 1'b0;

   int tab_mach  [16] = '{0,0,3,3,0,0,0,0,0,4,4,5,1,5,3,1};
   int tab_other [16] = '{0,4,1,3,1,5,3,7,0,0,4,4,0,0,0,1};

   pmp_check #(
      .NUM_ENTRIES (BN),
      .ADDR_REG_W  (BAW),
      .ENHANCED    (1'b1)
   ) u_pmp_check (
      .cfg_flat      (cfg_flat),
      .addr_flat     (addr_flat),
      .sec_lockdown  (sec_lockdown),
      .sec_whitelist (sec_whitelist),
      .acc_addr      (acc_addr),
      .acc_size_log2 (acc_size_log2),
      .acc_req       (acc_req),
      .acc_mode      (acc_mode),
      .allow_o       (allow_o),
      .pass_o        (pass_o)
   );

   function automatic logic [7:0] mk(input bit l, input int am, input bit x, input bit w, input bit r);
      return {l, 2'b00, am[1:0], x, w, r};
   endfunction

   // Expected result from the requirements: region arithmetic, priority, tables.
   function automatic void model(input int addr, input int szl, input int req, input int mode,
                                 output int ea, output bit ep, output string tag);
      int  last;
      int  lo, hi, k, span, am, lrwx;
      bit  fi, la, hit;
      last = addr + (1 << szl) - 1;
      ea = 0; ep = 1'b0; tag = "R9";
      for (int i = 0; i < BN; i++) begin
         am  = int'(cfg_m[i][4:3]);
         hit = 1'b1;
         lo  = 0; hi = 0;
         if (am == 0) hit = 1'b0;                       // R3 off
         else if (am == 1) begin                        // R2
            lo = (i == 0) ? 0 : areg_m[i-1] * 4;
            hi = areg_m[i] * 4 - 1;
            if (lo > hi) hit = 1'b0;
         end else if (am == 2) begin                    // R3
            lo = areg_m[i] * 4;
            hi = lo + 3;
         end else begin                                 // R1
            k = 0;
            while (k < BAW && ((areg_m[i] >> k) & 1) == 1) k++;
            span = 1 << (k + 3);
            lo = ((areg_m[i] * 4 + 3) / span) * span;
            hi = lo + span - 1;
         end
         if (hit) begin
            fi = (addr >= lo) && (addr <= hi);
            la = (last >= lo) && (last <= hi);
            if (fi != la) begin
               ea = 0; ep = 1'b0; tag = "R5";
               return;
            end
            if (fi && la) begin
               lrwx = {cfg_m[i][7], cfg_m[i][0], cfg_m[i][1], cfg_m[i][2]};
               if (!sec_lockdown) begin
                  ea = (mode == 3 && !cfg_m[i][7]) ? 7 : int'(cfg_m[i][2:0]);
                  tag = "R6";
               end else if (mode == 3) begin
                  ea = tab_mach[lrwx];  tag = "R7";
               end else begin
                  ea = tab_other[lrwx]; tag = "R8";
               end
               case (am)
                  1: tag = {tag, " R2"};
                  2: tag = {tag, " R3"};
                  default: tag = {tag, " R1"};
               endcase
               if (i > 0) tag = {tag, " R4"};
               if (szl != 0) tag = {tag, " R11"};
               ep = ((req & ~ea) & 7) == 0;
               tag = {tag, " R10"};
               return;
            end
         end
      end
      if (sec_whitelist)      ea = 0;
      else if (sec_lockdown)  ea = (mode == 3 && (req & 4) == 0) ? 3 : 0;
      else                    ea = (mode == 3) ? 7 : 0;
      ep = ((req & ~ea) & 7) == 0;
      tag = "R9 R10";
   endfunction

   task automatic load_rules();
      for (int i = 0; i < BN; i++) begin
         cfg_flat[i*8 +: 8]      = cfg_m[i];
         addr_flat[i*BAW +: BAW] = BAW'(areg_m[i]);
      end
   endtask

   task automatic apply_one(input int addr, input int szl, input int req, input int mode);
      int    ea;
      bit    ep;
      string tag;
      acc_addr      = BPA'(addr);
      acc_size_log2 = 2'(szl);
      acc_req       = 3'(req);
      acc_mode      = 2'(mode);
      #1;
      model(addr, szl, req, mode, ea, ep, tag);
      n_vec++;
      if (allow_o !== 3'(ea) || pass_o !== ep) begin
         n_bad++;
         $display("FAIL %s addr=%0d size_log2=%0d req=%0d mode=%0d: allow=%0d pass=%0d expected allow=%0d pass=%0d",
                  tag, addr, szl, req, mode, allow_o, pass_o, ea, ep);
      end
      #1;
   endtask

   task automatic sweep();
      int modes [3] = '{0, 1, 3};
      load_rules();
      for (int a = 0; a < (1 << BPA); a++)
         for (int s = 0; s < 4; s++)
            for (int r = 0; r < 8; r++)
               for (int m = 0; m < 3; m++)
                  apply_one(a, s, r, modes[m]);
   endtask

   initial begin
      for (int i = 0; i < BN; i++) begin
         cfg_m[i] = 8'h00; areg_m[i] = 0;
      end
      sec_lockdown = 1'b0; sec_whitelist = 1'b0;
      load_rules();
      acc_addr = '0; acc_size_log2 = '0; acc_req = 3'b001; acc_mode = 2'd0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      #1;
      // Reset-like state: all rules off, user read denied (R9)
      apply_one(0, 0, 1, 0);

      // Overlapping NA4, NAPOT and TOR rules, plain defaults
      cfg_m[0] = mk(0, 2, 0, 0, 1); areg_m[0] = 'h04;
      cfg_m[1] = mk(1, 3, 0, 1, 1); areg_m[1] = 'h0B;
      cfg_m[2] = mk(0, 1, 1, 0, 0); areg_m[2] = 'h14;
      cfg_m[3] = mk(0, 0, 1, 1, 1); areg_m[3] = 'h3F;
      sweep();

      // Same rules, whitelist default and a locked TOR
      sec_whitelist = 1'b1;
      cfg_m[2] = mk(1, 1, 1, 0, 0);
      sweep();

      // Lockdown default path with every rule off
      sec_whitelist = 1'b0; sec_lockdown = 1'b1;
      for (int i = 0; i < BN; i++) cfg_m[i] = 8'h00;
      sweep();

      // TOR from zero, empty TOR, whole-space NAPOT
      sec_lockdown = 1'b0;
      cfg_m[0] = mk(1, 1, 0, 0, 1); areg_m[0] = 'h08;
      cfg_m[1] = mk(0, 1, 1, 1, 1); areg_m[1] = 'h05;
      cfg_m[2] = mk(0, 1, 0, 1, 0); areg_m[2] = 'h10;
      cfg_m[3] = mk(1, 3, 1, 0, 0); areg_m[3] = 'h3F;
      sweep();

      // Every lockdown table index across four quarter-space rules
      sec_lockdown = 1'b1;
      for (int k = 0; k < 4; k++) begin
         sec_whitelist = (k == 1);
         for (int j = 0; j < BN; j++) begin
            int idx;
            idx = 4 * k + j;
            cfg_m[j]  = mk(idx[3], 3, idx[0], idx[1], idx[2]);
            areg_m[j] = 16 * j + 7;
         end
         sweep();
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired: progress=%0d expected completion", n_vec);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule